// File: doc/BRIEF.md
# Variable Block Size SAD Merge Tree

This block turns the sixteen 4x4 sums of absolute differences of one candidate search position into the sums for every partition shape a macroblock can be split into. It yields 41 values: sixteen 4x4, eight 8x4 (8 wide, 4 tall), eight 4x8 (4 wide, 8 tall), four 8x8, two 16x8, two 8x16 and one 16x16. Every wider sum is formed from the 4x4 sums alone. No pixel data reaches this block, and no motion-vector cost term is added at any level.

A full-search engine presents one set of 4x4 sums per cycle with a valid strobe. The set is captured in one register stage. All 41 merged sums then appear together in the following cycle, with a matching valid. Downstream minimum trackers can compare every shape at once.

Top module: `vbs_sad_merge_top`

## Requirements
- R1: After reset, out_valid is 0 and every output sum is 0.
- R2: When in_valid is 1 at a rising edge, out_valid is 1 in the next cycle and out_sad4 equals the captured input set. When in_valid is 0 at an edge, out_valid is 0 in the next cycle.
- R3: Element i of in_sad4 and out_sad4 occupies bits [i*12 +: 12] and is the 4x4 block at row i/4, column i%4. Each 8x4 sum k (bits [k*13 +: 13]) equals 4x4 (row k/2, column 2*(k%2)) plus its right neighbour.
- R4: Each 4x8 sum k (bits [k*13 +: 13]) equals 4x4 (row 2*(k/4), column k%4) plus the 4x4 directly below it.
- R5: Each 8x8 sum q (bits [q*14 +: 14]) equals the four 4x4 sums in rows 2*(q/2)..+1 and columns 2*(q%2)..+1. The sum is the same whether it is built from 8x4 or from 4x8 pairs.
- R6: 16x8 sum h (bits [h*15 +: 15], 0 = top) covers 4x4 rows 2h..2h+1. 8x16 sum v (bits [v*15 +: 15], 0 = left) covers 4x4 columns 2v..2v+1.
- R7: The 16x16 sum equals the total of all sixteen 4x4 sums and also equals the sum of the two 8x16 values.
- R8: While in_valid is 0, changes on in_sad4 have no effect: all output sums keep their values.
- R9: With every 4x4 input at 4095, each level is exact with no wrap: 8190, 16380, 32760 and 65520.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input set valid |
| in_sad4 | input | 192 | Sixteen 4x4 sums, raster order |
| out_valid | output | 1 | Output set valid |
| out_sad4 | output | 192 | Registered 4x4 sums |
| out_sad8x4 | output | 104 | Eight 8x4 sums |
| out_sad4x8 | output | 104 | Eight 4x8 sums |
| out_sad8x8 | output | 56 | Four 8x8 sums |
| out_sad16x8 | output | 30 | Two 16x8 sums |
| out_sad8x16 | output | 30 | Two 8x16 sums |
| out_sad16x16 | output | 16 | 16x16 sum |

## Verification
The embedded properties check these on every cycle: the one-cycle valid latency, the hold of all results while no new set arrives, and agreement of sums reached along different merge paths (8x8 from row pairs against column pairs, and 16x16 from halves split either way). Whether each merged value covers the right rectangle of 4x4 blocks, the exact index placement, and full-scale width behaviour show only in the bench's scenarios. There, the bench recomputes each shape as a rectangle sum over the 4x4 grid.

// File: rtl/vbs_sad_pkg.sv
package vbs_sad_pkg;
  // 4x4 blocks per macroblock side
  localparam int unsigned GRID      = 4;
  localparam int unsigned N_SAD4    = GRID * GRID;
  localparam int unsigned N_HALF    = N_SAD4 / 2;
  localparam int unsigned N_QUAD    = N_SAD4 / 4;
  localparam int unsigned SAD4_W_DF = 12;
endpackage

// File: rtl/vbs_pair_adder.sv
module vbs_pair_adder #(
  parameter int unsigned IN_W = 12
) (
  input  logic [IN_W-1:0] a,
  input  logic [IN_W-1:0] b,
  output logic [IN_W:0]   s
);
  // one bit of growth per merge level, never wraps
  assign s = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/vbs_in_reg.sv
module vbs_in_reg #(
  parameter int unsigned W = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         vld,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end

  // R2: valid follows load by exactly one edge
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    vld == $past(load));
  // R8: stored set changes only on a load
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(q));
endmodule

// File: rtl/vbs_level1.sv
module vbs_level1
  import vbs_sad_pkg::*;
#(
  parameter int unsigned W = SAD4_W_DF
) (
  input  logic [N_SAD4*W-1:0]     s4,
  output logic [N_HALF*(W+1)-1:0] s8x4,
  output logic [N_HALF*(W+1)-1:0] s4x8
);
  localparam int unsigned OW = W + 1;

  for (genvar k = 0; k < N_HALF; k++) begin : g_pair
    // horizontal pair: row k/2, columns 2*(k%2) and +1
    localparam int unsigned HA = (k / 2) * GRID + (k % 2) * 2;
    // vertical pair: rows 2*(k/4) and +1, column k%4
    localparam int unsigned VA = (k / GRID) * 2 * GRID + (k % GRID);

    vbs_pair_adder #(.IN_W(W)) u_h (
      .a(s4[HA*W +: W]), .b(s4[(HA+1)*W +: W]), .s(s8x4[k*OW +: OW]));
    vbs_pair_adder #(.IN_W(W)) u_v (
      .a(s4[VA*W +: W]), .b(s4[(VA+GRID)*W +: W]), .s(s4x8[k*OW +: OW]));
  end
endmodule

// File: rtl/vbs_level2.sv
module vbs_level2
  import vbs_sad_pkg::*;
#(
  parameter int unsigned W = SAD4_W_DF
) (
  input  logic [N_HALF*(W+1)-1:0] s8x4,
  output logic [N_QUAD*(W+2)-1:0] s8x8,
  output logic [2*(W+3)-1:0]      s16x8,
  output logic [2*(W+3)-1:0]      s8x16,
  output logic [W+3:0]            s16x16
);
  localparam int unsigned W1 = W + 1;
  localparam int unsigned W2 = W + 2;
  localparam int unsigned W3 = W + 3;

  for (genvar q = 0; q < N_QUAD; q++) begin : g_quad
    // 8x4 at rows 2*(q/2), 2*(q/2)+1, half-column q%2
    localparam int unsigned TA = (q / 2) * 4 + (q % 2);
    vbs_pair_adder #(.IN_W(W1)) u_q (
      .a(s8x4[TA*W1 +: W1]), .b(s8x4[(TA+2)*W1 +: W1]), .s(s8x8[q*W2 +: W2]));
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    vbs_pair_adder #(.IN_W(W2)) u_wide (
      .a(s8x8[(2*h)*W2 +: W2]), .b(s8x8[(2*h+1)*W2 +: W2]),
      .s(s16x8[h*W3 +: W3]));
    vbs_pair_adder #(.IN_W(W2)) u_tall (
      .a(s8x8[h*W2 +: W2]), .b(s8x8[(h+2)*W2 +: W2]),
      .s(s8x16[h*W3 +: W3]));
  end

  vbs_pair_adder #(.IN_W(W3)) u_mb (
    .a(s16x8[0 +: W3]), .b(s16x8[W3 +: W3]), .s(s16x16));
endmodule

// File: rtl/vbs_sad_merge_top.sv
module vbs_sad_merge_top
  import vbs_sad_pkg::*;
#(
  parameter int unsigned SAD4_W = SAD4_W_DF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [N_SAD4*SAD4_W-1:0]     in_sad4,
  output logic                         out_valid,
  output logic [N_SAD4*SAD4_W-1:0]     out_sad4,
  output logic [N_HALF*(SAD4_W+1)-1:0] out_sad8x4,
  output logic [N_HALF*(SAD4_W+1)-1:0] out_sad4x8,
  output logic [N_QUAD*(SAD4_W+2)-1:0] out_sad8x8,
  output logic [2*(SAD4_W+3)-1:0]      out_sad16x8,
  output logic [2*(SAD4_W+3)-1:0]      out_sad8x16,
  output logic [SAD4_W+3:0]            out_sad16x16
);
  localparam int unsigned IN_BITS = N_SAD4 * SAD4_W;
  localparam int unsigned W1 = SAD4_W + 1;
  localparam int unsigned W2 = SAD4_W + 2;
  localparam int unsigned W3 = SAD4_W + 3;
  localparam int unsigned W4 = SAD4_W + 4;

  vbs_in_reg #(.W(IN_BITS)) u_in (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .d(in_sad4),
    .vld(out_valid), .q(out_sad4));

  vbs_level1 #(.W(SAD4_W)) u_l1 (
    .s4(out_sad4), .s8x4(out_sad8x4), .s4x8(out_sad4x8));

  vbs_level2 #(.W(SAD4_W)) u_l2 (
    .s8x4(out_sad8x4), .s8x8(out_sad8x8), .s16x8(out_sad16x8),
    .s8x16(out_sad8x16), .s16x16(out_sad16x16));

  // Cross-path sums for the checks: 8x8 from column pairs, 16x16 from 8x16 halves
  logic [N_QUAD*W2-1:0] chk_8x8_by_cols;
  logic [W4-1:0]        chk_16x16_by_cols;

  for (genvar q = 0; q < N_QUAD; q++) begin : g_chk
    localparam int unsigned CA = (q / 2) * 4 + (q % 2) * 2;
    vbs_pair_adder #(.IN_W(W1)) u_c (
      .a(out_sad4x8[CA*W1 +: W1]), .b(out_sad4x8[(CA+1)*W1 +: W1]),
      .s(chk_8x8_by_cols[q*W2 +: W2]));
  end
  vbs_pair_adder #(.IN_W(W3)) u_c16 (
    .a(out_sad8x16[0 +: W3]), .b(out_sad8x16[W3 +: W3]), .s(chk_16x16_by_cols));

  // R5: row-pair and column-pair merges agree
  a_r5_8x8_paths: assert property (@(posedge clk) disable iff (!rst_n)
    out_sad8x8 == chk_8x8_by_cols);
  // R7: both ways of halving the macroblock give the same total
  a_r7_16x16_paths: assert property (@(posedge clk) disable iff (!rst_n)
    out_sad16x16 == chk_16x16_by_cols);
  // R8: the whole result set holds while idle
  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_sad16x16) && $stable(out_sad8x8)));
  // R2: captured 4x4 set reappears one cycle later
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> (out_valid && out_sad4 == $past(in_sad4)));
endmodule

// File: tb/vbs_sad_merge_top_tb_top.sv
module vbs_sad_merge_top_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [191:0] in_sad4 = '0;
  logic         out_valid;
  logic [191:0] out_sad4;
  logic [103:0] out_sad8x4, out_sad4x8;
  logic [55:0]  out_sad8x8;
  logic [29:0]  out_sad16x8, out_sad8x16;
  logic [15:0]  out_sad16x16;

  int n_checks = 0;
  int n_fail   = 0;
  int grid [16];

  always #5 clk = ~clk;

  vbs_sad_merge_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sad4(in_sad4),
    .out_valid(out_valid), .out_sad4(out_sad4), .out_sad8x4(out_sad8x4),
    .out_sad4x8(out_sad4x8), .out_sad8x8(out_sad8x8), .out_sad16x8(out_sad16x8),
    .out_sad8x16(out_sad8x16), .out_sad16x16(out_sad16x16));

  task automatic chk(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // rectangle of 4x4 blocks: top row r0, left col c0, h rows, w cols
  function automatic int rect(int r0, int c0, int h, int w);
    int s = 0;
    for (int r = r0; r < r0 + h; r++)
      for (int c = c0; c < c0 + w; c++) s += grid[r*4 + c];
    return s;
  endfunction

  task automatic check_all(string tag);
    for (int i = 0; i < 16; i++) chk({"R2 4x4 ", tag}, int'(out_sad4[i*12 +: 12]), grid[i]);
    for (int k = 0; k < 8; k++) begin
      chk({"R3 8x4 ", tag}, int'(out_sad8x4[k*13 +: 13]), rect(k/2, (k%2)*2, 1, 2));
      chk({"R4 4x8 ", tag}, int'(out_sad4x8[k*13 +: 13]), rect((k/4)*2, k%4, 2, 1));
    end
    for (int q = 0; q < 4; q++)
      chk({"R5 8x8 ", tag}, int'(out_sad8x8[q*14 +: 14]), rect((q/2)*2, (q%2)*2, 2, 2));
    for (int h = 0; h < 2; h++) begin
      chk({"R6 16x8 ", tag}, int'(out_sad16x8[h*15 +: 15]), rect(h*2, 0, 2, 4));
      chk({"R6 8x16 ", tag}, int'(out_sad8x16[h*15 +: 15]), rect(0, h*2, 4, 2));
    end
    chk({"R7 16x16 ", tag}, int'(out_sad16x16), rect(0, 0, 4, 4));
  endtask

  task automatic apply(string tag);
    @(negedge clk);
    for (int i = 0; i < 16; i++) in_sad4[i*12 +: 12] = 12'(grid[i]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R2 valid ", tag}, int'(out_valid), 1);
    check_all(tag);
  endtask

  initial begin : watchdog
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int i = 0; i < 16; i++) grid[i] = 0;
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 16x16", int'(out_sad16x16), 0);
    check_all("reset");

    // R9: full scale
    for (int i = 0; i < 16; i++) grid[i] = 4095;
    apply("R9 max");
    chk("R9 8x4 max", int'(out_sad8x4[0 +: 13]), 8190);
    chk("R9 8x8 max", int'(out_sad8x8[0 +: 14]), 16380);
    chk("R9 16x8 max", int'(out_sad16x8[15 +: 15]), 32760);
    chk("R9 16x16 max", int'(out_sad16x16), 65520);

    // one-hot blocks expose index placement (R3 R4 R5 R6)
    for (int j = 0; j < 16; j++) begin
      for (int i = 0; i < 16; i++) grid[i] = (i == j) ? (j + 1) * 100 : 0;
      apply("onehot");
    end

    // R2: no valid means out_valid falls next cycle
    @(negedge clk);
    chk("R2 valid low", int'(out_valid), 0);

    // R8: idle input changes are ignored
    for (int i = 0; i < 16; i++) grid[i] = 7 * i + 3;
    apply("pre-hold");
    for (int i = 0; i < 16; i++) in_sad4[i*12 +: 12] = 12'($urandom_range(4095));
    repeat (3) @(negedge clk);
    check_all("R8 hold");

    // random sets, some back to back
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < 16; i++) grid[i] = int'($urandom_range(4095));
      apply("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule